// File: doc/BRIEF.md
# Segment Table Address Translator

This block turns a segmented logical address into a physical address. A requester presents a segment number, an offset inside that segment and the kind of access: data read, data write or instruction fetch. A small table of registers holds one entry per segment. Each entry has a physical start address, a segment length, a valid flag and three permission flags. A separate length register states how many segments the current program uses. The block checks the segment number against that count, the valid flag, the length and the permissions. If every check passes it returns start address plus offset. If any check fails it returns a trap with a two-bit cause, and the address reads as zero.

Software loads entries through a one-entry-per-cycle write port and loads the length register through its own strobe. Translation results are registered and come back one cycle after a request is taken. Valid/ready handshakes sit on both the request side and the response side, so a stalled consumer holds the result and back-pressures new requests.

The response side is a two-state machine. In `RSP_IDLE` no result is held. `RSP_HOLD` presents a result. The transitions are: idle-to-hold when a request is accepted; hold-to-hold when a new request is accepted while the old result drains, or while the consumer stalls; hold-to-idle when the result drains with no new request.

Top module: `seg_xlate_top`

## Requirements
- R1: After reset, no response is pending, `req_ready` is 1, every valid flag is cleared and the segment count is 0, so every request faults with cause 01 until the table is loaded.
- R2: A request whose segment number is greater than or equal to the segment count faults with cause 01. This check has priority over all others.
- R3: A request to a segment in range whose valid flag is 0 faults with cause 10. This check takes priority over the length and permission checks.
- R4: For a valid segment in range, an offset greater than or equal to the segment length faults with cause 11. An offset of length minus one is legal.
- R5: Access codes are 00 read, 01 write and 10 fetch, and they are checked against permission bits 0, 1 and 2 of the entry. An access whose bit is 0 faults with cause 11. Code 11 always faults with cause 11.
- R6: A request passing all checks responds with fault 0, cause 00 and address equal to start plus offset, modulo 2^PA_W. A faulting response carries fault 1, a nonzero cause and address 0.
- R7: A response appears in the cycle after its request is accepted. While `rsp_valid` is 1 and `rsp_ready` is 0, the response holds every field unchanged.
- R8: `req_ready` is 0 exactly when a response is held and `rsp_ready` is 0.
- R9: A table or length write in the same cycle as an accepted request does not affect that request. It applies from the next request onward.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Request can be taken |
| req_seg | input | SEG_W | Segment number |
| req_off | input | OFF_W | Offset within segment |
| req_acc | input | 2 | Access kind: 00 read, 01 write, 10 fetch |
| rsp_valid | output | 1 | Result held |
| rsp_ready | input | 1 | Consumer takes result |
| rsp_fault | output | 1 | Trap instead of address |
| rsp_cause | output | 2 | 00 none, 01 range, 10 invalid, 11 length or permission |
| rsp_paddr | output | PA_W | Physical address, 0 on trap |
| tw_en | input | 1 | Table entry write strobe |
| tw_idx | input | SEG_W | Entry written |
| tw_base | input | PA_W | Physical start address |
| tw_limit | input | OFF_W+1 | Segment length |
| tw_valid | input | 1 | Valid flag |
| tw_perm | input | 3 | Permissions: bit0 read, bit1 write, bit2 fetch |
| tlen_we | input | 1 | Segment count write strobe |
| tlen_data | input | SEG_W+1 | New segment count |

## Verification
The bench first tries requests with an empty table. This separates the reset state from a table that was loaded by mistake. Directed patterns follow, one failing check at a time: segment number at and above the count, a cleared valid flag, offsets at length and at length minus one, and each access kind against single-permission entries. Layered faults show whether the cause priority is respected. Stalls with `rsp_ready` held low separate correct holding and back-pressure from dropped or overwritten results. Writes that coincide with a request to the same entry show whether the request sees old or new contents. A long random mix of table loads, requests and stalls is then compared against a behavioural model on every clock.

// File: rtl/seg_xlate_pkg.sv
package seg_xlate_pkg;

    typedef enum logic [1:0] {
        ACC_READ  = 2'b00,
        ACC_WRITE = 2'b01,
        ACC_FETCH = 2'b10,
        ACC_RSVD  = 2'b11
    } acc_e;

    typedef enum logic [1:0] {
        CAUSE_NONE    = 2'b00,
        CAUSE_RANGE   = 2'b01,
        CAUSE_INVALID = 2'b10,
        CAUSE_ACCESS  = 2'b11
    } cause_e;

    localparam int PERM_W = 3;

endpackage

// File: rtl/seg_table.sv
module seg_table #(
    parameter int SEG_W  = 3,
    parameter int OFF_W  = 12,
    parameter int PA_W   = 16,
    localparam int NSEG   = 1 << SEG_W,
    localparam int TLEN_W = SEG_W + 1,
    localparam int LIM_W  = OFF_W + 1
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 tw_en,
    input  logic [SEG_W-1:0]     tw_idx,
    input  logic [PA_W-1:0]      tw_base,
    input  logic [LIM_W-1:0]     tw_limit,
    input  logic                 tw_valid,
    input  logic [2:0]           tw_perm,
    input  logic                 tlen_we,
    input  logic [TLEN_W-1:0]    tlen_data,
    input  logic [SEG_W-1:0]     rd_idx,
    output logic [PA_W-1:0]      rd_base,
    output logic [LIM_W-1:0]     rd_limit,
    output logic                 rd_valid,
    output logic [2:0]           rd_perm,
    output logic [TLEN_W-1:0]    tlen_q
);

    logic [PA_W-1:0]  base_q  [NSEG];
    logic [LIM_W-1:0] limit_q [NSEG];
    logic [2:0]       perm_q  [NSEG];
    logic [NSEG-1:0]  valid_q;

    genvar gi;
    generate
        for (gi = 0; gi < NSEG; gi++) begin : g_entry
            logic hit;
            assign hit = tw_en && (tw_idx == SEG_W'(gi));

            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) begin
                    valid_q[gi] <= 1'b0;
                end else if (hit) begin
                    valid_q[gi] <= tw_valid;
                end
            end

            always_ff @(posedge clk) begin
                if (hit) begin
                    base_q[gi]  <= tw_base;
                    limit_q[gi] <= tw_limit;
                    perm_q[gi]  <= tw_perm;
                end
            end
        end
    endgenerate

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            tlen_q <= '0;
        end else if (tlen_we) begin
            tlen_q <= tlen_data;
        end
    end

    always_comb begin
        rd_base  = base_q[rd_idx];
        rd_limit = limit_q[rd_idx];
        rd_perm  = perm_q[rd_idx];
        rd_valid = valid_q[rd_idx];
    end

    // R1: the count only moves on its strobe
    assert_tlen_hold_R1: assert property (@(posedge clk) disable iff (!rst_n)
        !tlen_we |=> (tlen_q == $past(tlen_q)));

endmodule

// File: rtl/seg_check.sv
module seg_check
    import seg_xlate_pkg::*;
#(
    parameter int SEG_W  = 3,
    parameter int OFF_W  = 12,
    parameter int PA_W   = 16,
    localparam int TLEN_W = SEG_W + 1,
    localparam int LIM_W  = OFF_W + 1
) (
    input  logic [SEG_W-1:0]  seg,
    input  logic [OFF_W-1:0]  off,
    input  logic [1:0]        acc,
    input  logic [TLEN_W-1:0] tlen,
    input  logic [PA_W-1:0]   ent_base,
    input  logic [LIM_W-1:0]  ent_limit,
    input  logic              ent_valid,
    input  logic [2:0]        ent_perm,
    output logic              fault,
    output logic [1:0]        cause,
    output logic [PA_W-1:0]   paddr
);

    logic in_range;
    logic in_length;
    logic perm_ok;
    logic [PA_W-1:0] off_ext;
    logic [PA_W-1:0] sum;

    always_comb begin
        in_range  = {1'b0, seg} < tlen;
        in_length = {1'b0, off} < ent_limit;
        unique case (acc_e'(acc))
            ACC_READ:  perm_ok = ent_perm[0];
            ACC_WRITE: perm_ok = ent_perm[1];
            ACC_FETCH: perm_ok = ent_perm[2];
            ACC_RSVD:  perm_ok = 1'b0;
        endcase
    end

    generate
        if (PA_W > OFF_W) begin : g_wide
            assign off_ext = {{(PA_W-OFF_W){1'b0}}, off};
        end else begin : g_narrow
            assign off_ext = off[PA_W-1:0];
        end
    endgenerate

    assign sum = ent_base + off_ext;

    always_comb begin
        if (!in_range) begin
            cause = CAUSE_RANGE;
        end else if (!ent_valid) begin
            cause = CAUSE_INVALID;
        end else if (!in_length || !perm_ok) begin
            cause = CAUSE_ACCESS;
        end else begin
            cause = CAUSE_NONE;
        end
        fault = (cause != CAUSE_NONE);
        paddr = fault ? '0 : sum;
    end

endmodule

// File: rtl/seg_resp.sv
module seg_resp #(
    parameter int PA_W = 16
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            req_valid,
    output logic            req_ready,
    output logic            rsp_valid,
    input  logic            rsp_ready,
    input  logic            in_fault,
    input  logic [1:0]      in_cause,
    input  logic [PA_W-1:0] in_paddr,
    output logic            rsp_fault,
    output logic [1:0]      rsp_cause,
    output logic [PA_W-1:0] rsp_paddr
);

    typedef enum logic {
        RSP_IDLE = 1'b0,
        RSP_HOLD = 1'b1
    } rsp_state_e;

    rsp_state_e state_q, state_d;
    logic accept;

    assign req_ready = (state_q == RSP_IDLE) || rsp_ready;
    assign accept    = req_valid && req_ready;
    assign rsp_valid = (state_q == RSP_HOLD);

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            RSP_IDLE: begin
                if (accept) state_d = RSP_HOLD;
            end
            RSP_HOLD: begin
                if (accept)         state_d = RSP_HOLD;
                else if (rsp_ready) state_d = RSP_IDLE;
            end
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= RSP_IDLE;
        else        state_q <= state_d;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rsp_fault <= 1'b0;
            rsp_cause <= 2'b00;
            rsp_paddr <= '0;
        end else if (accept) begin
            rsp_fault <= in_fault;
            rsp_cause <= in_cause;
            rsp_paddr <= in_paddr;
        end
    end

    assert_latency_R7: assert property (@(posedge clk) disable iff (!rst_n)
        accept |=> rsp_valid);

    assert_stall_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_valid && !rsp_ready) |=> (rsp_valid && $stable(rsp_fault)
                                       && $stable(rsp_cause) && $stable(rsp_paddr)));

    assert_backpressure_R8: assert property (@(posedge clk) disable iff (!rst_n)
        !req_ready |-> (rsp_valid && !rsp_ready));

    assert_fault_zero_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_valid && rsp_fault) |-> (rsp_paddr == '0 && rsp_cause != 2'b00));

    assert_clean_cause_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_valid && !rsp_fault) |-> (rsp_cause == 2'b00));

endmodule

// File: rtl/seg_xlate_top.sv
module seg_xlate_top #(
    parameter int SEG_W  = 3,
    parameter int OFF_W  = 12,
    parameter int PA_W   = 16,
    localparam int TLEN_W = SEG_W + 1,
    localparam int LIM_W  = OFF_W + 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    output logic              req_ready,
    input  logic [SEG_W-1:0]  req_seg,
    input  logic [OFF_W-1:0]  req_off,
    input  logic [1:0]        req_acc,
    output logic              rsp_valid,
    input  logic              rsp_ready,
    output logic              rsp_fault,
    output logic [1:0]        rsp_cause,
    output logic [PA_W-1:0]   rsp_paddr,
    input  logic              tw_en,
    input  logic [SEG_W-1:0]  tw_idx,
    input  logic [PA_W-1:0]   tw_base,
    input  logic [LIM_W-1:0]  tw_limit,
    input  logic              tw_valid,
    input  logic [2:0]        tw_perm,
    input  logic              tlen_we,
    input  logic [TLEN_W-1:0] tlen_data
);

    logic [PA_W-1:0]   ent_base;
    logic [LIM_W-1:0]  ent_limit;
    logic              ent_valid;
    logic [2:0]        ent_perm;
    logic [TLEN_W-1:0] tlen_q;
    logic              chk_fault;
    logic [1:0]        chk_cause;
    logic [PA_W-1:0]   chk_paddr;

    seg_table #(.SEG_W(SEG_W), .OFF_W(OFF_W), .PA_W(PA_W)) u_table (
        .clk       (clk),
        .rst_n     (rst_n),
        .tw_en     (tw_en),
        .tw_idx    (tw_idx),
        .tw_base   (tw_base),
        .tw_limit  (tw_limit),
        .tw_valid  (tw_valid),
        .tw_perm   (tw_perm),
        .tlen_we   (tlen_we),
        .tlen_data (tlen_data),
        .rd_idx    (req_seg),
        .rd_base   (ent_base),
        .rd_limit  (ent_limit),
        .rd_valid  (ent_valid),
        .rd_perm   (ent_perm),
        .tlen_q    (tlen_q)
    );

    seg_check #(.SEG_W(SEG_W), .OFF_W(OFF_W), .PA_W(PA_W)) u_check (
        .seg       (req_seg),
        .off       (req_off),
        .acc       (req_acc),
        .tlen      (tlen_q),
        .ent_base  (ent_base),
        .ent_limit (ent_limit),
        .ent_valid (ent_valid),
        .ent_perm  (ent_perm),
        .fault     (chk_fault),
        .cause     (chk_cause),
        .paddr     (chk_paddr)
    );

    seg_resp #(.PA_W(PA_W)) u_resp (
        .clk       (clk),
        .rst_n     (rst_n),
        .req_valid (req_valid),
        .req_ready (req_ready),
        .rsp_valid (rsp_valid),
        .rsp_ready (rsp_ready),
        .in_fault  (chk_fault),
        .in_cause  (chk_cause),
        .in_paddr  (chk_paddr),
        .rsp_fault (rsp_fault),
        .rsp_cause (rsp_cause),
        .rsp_paddr (rsp_paddr)
    );

    assert_range_first_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_ready && ({1'b0, req_seg} >= tlen_q)) |=> (rsp_cause == 2'b01));

    assert_invalid_second_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_ready && ({1'b0, req_seg} < tlen_q) && !ent_valid)
            |=> (rsp_cause == 2'b10));

endmodule

// File: tb/tb_seg_xlate_top.sv
`timescale 1ns/1ps
module tb_seg_xlate_top;

    localparam int SEG_W = 3;
    localparam int OFF_W = 12;
    localparam int PA_W  = 16;
    localparam int NSEG  = 1 << SEG_W;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic req_valid = 0, req_ready;
    logic [SEG_W-1:0] req_seg = 0;
    logic [OFF_W-1:0] req_off = 0;
    logic [1:0] req_acc = 0;
    logic rsp_valid, rsp_ready = 1, rsp_fault;
    logic [1:0] rsp_cause;
    logic [PA_W-1:0] rsp_paddr;
    logic tw_en = 0;
    logic [SEG_W-1:0] tw_idx = 0;
    logic [PA_W-1:0] tw_base = 0;
    logic [OFF_W:0] tw_limit = 0;
    logic tw_valid = 0;
    logic [2:0] tw_perm = 0;
    logic tlen_we = 0;
    logic [SEG_W:0] tlen_data = 0;

    always #2 clk = ~clk;

    seg_xlate_top #(.SEG_W(SEG_W), .OFF_W(OFF_W), .PA_W(PA_W)) dut (.*);

    int m_base [NSEG];
    int m_lim  [NSEG];
    bit m_val  [NSEG];
    bit [2:0] m_perm [NSEG];
    int m_tlen;
    bit e_valid;
    bit e_fault;
    int e_cause;
    int e_paddr;
    int vectors = 0;
    int miscompares = 0;
    string tag = "R1";
    bit done = 0;

    function automatic int model_cause(int seg, int off, int acc);
        if (seg >= m_tlen) return 1;
        if (!m_val[seg]) return 2;
        if (off >= m_lim[seg]) return 3;
        if (acc == 3) return 3;
        if (!m_perm[seg][acc]) return 3;
        return 0;
    endfunction

    task automatic finish_run();
        if (!done) begin
            done = 1;
            $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
            $finish;
        end
    endtask

    task automatic step();
        bit acc_ok;
        bit bad;
        int c;
        #1;
        vectors++;
        if (req_ready !== (!e_valid || rsp_ready)) begin
            miscompares++;
            $display("FAIL %s req_ready got %0b exp %0b", tag, req_ready, (!e_valid || rsp_ready));
        end
        acc_ok = req_valid && (!e_valid || rsp_ready);
        @(posedge clk);
        if (acc_ok) begin
            c = model_cause(int'(req_seg), int'(req_off), int'(req_acc));
            e_valid = 1;
            e_cause = c;
            e_fault = (c != 0);
            e_paddr = (c != 0) ? 0 : ((m_base[req_seg] + int'(req_off)) % (1 << PA_W));
        end else if (rsp_ready) begin
            e_valid = 0;
        end
        if (tw_en) begin
            m_base[tw_idx] = int'(tw_base);
            m_lim[tw_idx]  = int'(tw_limit);
            m_val[tw_idx]  = tw_valid;
            m_perm[tw_idx] = tw_perm;
        end
        if (tlen_we) m_tlen = int'(tlen_data);
        @(negedge clk);
        vectors++;
        bad = (rsp_valid !== e_valid);
        if (e_valid && !bad)
            bad = (rsp_fault !== e_fault) || (int'(rsp_cause) != e_cause) || (int'(rsp_paddr) != e_paddr);
        if (bad) begin
            miscompares++;
            $display("FAIL %s rsp v/f/c/a got %0b/%0b/%0d/%0h exp %0b/%0b/%0d/%0h", tag,
                     rsp_valid, rsp_fault, rsp_cause, rsp_paddr, e_valid, e_fault, e_cause, e_paddr);
        end
    endtask

    task automatic idle_inputs();
        req_valid = 0; tw_en = 0; tlen_we = 0; rsp_ready = 1;
    endtask

    task automatic load(int idx, int base, int lim, bit v, bit [2:0] p);
        idle_inputs();
        tw_en = 1; tw_idx = SEG_W'(idx); tw_base = PA_W'(base);
        tw_limit = (OFF_W+1)'(lim); tw_valid = v; tw_perm = p;
        step();
        tw_en = 0;
    endtask

    task automatic set_len(int n);
        idle_inputs();
        tlen_we = 1; tlen_data = (SEG_W+1)'(n);
        step();
        tlen_we = 0;
    endtask

    task automatic xlate(int seg, int off, int acc);
        idle_inputs();
        req_valid = 1; req_seg = SEG_W'(seg); req_off = OFF_W'(off); req_acc = 2'(acc);
        step();
        req_valid = 0;
    endtask

    initial begin
        #(4 * 200000);
        miscompares++;
        $display("FAIL watchdog expired");
        finish_run();
    end

    initial begin
        for (int i = 0; i < NSEG; i++) begin
            m_base[i] = 0; m_lim[i] = 0; m_val[i] = 0; m_perm[i] = 0;
        end
        m_tlen = 0; e_valid = 0; e_fault = 0; e_cause = 0; e_paddr = 0;
        repeat (3) @(negedge clk);
        rst_n = 1;

        // R1: reset state, empty table faults with range cause
        tag = "R1";
        idle_inputs(); step();
        xlate(0, 0, 0);
        xlate(7, 5, 2);

        set_len(6);
        load(0, 'h1000, 'h100, 1, 3'b111);
        load(1, 'h2000, 'h10, 1, 3'b001);
        load(2, 'h3000, 'h10, 1, 3'b010);
        load(3, 'h4000, 'h10, 1, 3'b100);
        load(4, 'h5000, 'h10, 0, 3'b111);
        load(5, 'hFFF0, 'h1000, 1, 3'b111);
        load(6, 'h7000, 'h10, 1, 3'b111);

        // R2: segment at and above count, even when entry is valid
        tag = "R2";
        xlate(6, 0, 0);
        xlate(7, 'hFFF, 3);

        // R3: cleared valid flag beats length and permission errors
        tag = "R3";
        xlate(4, 0, 0);
        xlate(4, 'h800, 3);

        // R4: length boundary
        tag = "R4";
        xlate(1, 'hF, 0);
        xlate(1, 'h10, 0);
        xlate(0, 'hFF, 1);
        xlate(0, 'h100, 2);

        // R5: each access kind against single permissions
        tag = "R5";
        for (int s = 1; s <= 3; s++)
            for (int a = 0; a < 4; a++)
                xlate(s, 3, a);

        // R6: modular sum and full-length segment
        tag = "R6";
        xlate(5, 'h20, 0);
        xlate(5, 'hFFF, 2);
        xlate(0, 'h42, 2);

        // R7/R8: stall holds result, back-pressures request
        tag = "R7";
        idle_inputs(); req_valid = 1; req_seg = 0; req_off = 5; req_acc = 0; step();
        req_seg = 1; req_off = 1; rsp_ready = 0; step();
        tag = "R8";
        step(); step();
        rsp_ready = 1; step();
        req_valid = 0; step();

        // R9: write same cycle as request to same entry
        tag = "R9";
        idle_inputs(); req_valid = 1; req_seg = 2; req_off = 4; req_acc = 1;
        tw_en = 1; tw_idx = 2; tw_base = 'h9000; tw_limit = 'h2; tw_valid = 1; tw_perm = 3'b010;
        step();
        idle_inputs(); xlate(2, 4, 1); xlate(2, 1, 1);
        idle_inputs(); req_valid = 1; req_seg = 6; req_off = 0; req_acc = 0;
        tlen_we = 1; tlen_data = 7; step();
        idle_inputs(); xlate(6, 0, 0);

        // random mix, all rules together
        tag = "R6";
        for (int n = 0; n < 4000; n++) begin
            int r;
            idle_inputs();
            r = $urandom_range(0, 99);
            req_valid = (r < 60);
            req_seg = SEG_W'($urandom_range(0, NSEG-1));
            req_acc = 2'($urandom_range(0, 3));
            req_off = OFF_W'($urandom_range(0, 1) ? $urandom_range(0, 40) : $urandom_range(0, 4095));
            rsp_ready = ($urandom_range(0, 3) != 0);
            if ($urandom_range(0, 9) == 0) begin
                tw_en = 1; tw_idx = SEG_W'($urandom_range(0, NSEG-1));
                tw_base = PA_W'($urandom_range(0, 65535));
                tw_limit = (OFF_W+1)'($urandom_range(0, 40));
                tw_valid = ($urandom_range(0, 3) != 0);
                tw_perm = 3'($urandom_range(0, 7));
            end
            if ($urandom_range(0, 49) == 0) begin
                tlen_we = 1; tlen_data = (SEG_W+1)'($urandom_range(0, NSEG));
            end
            step();
        end
        idle_inputs(); step(); step();
        finish_run();
    end

endmodule